// File: doc/BRIEF.md
# CAN Receive Mailbox Controller

This block holds a single receive mailbox of a CAN controller. A frame-matching front end hands it complete frames: an identifier, up to eight data bytes, a length code and a one-cycle valid strobe. The mailbox compares each frame's identifier with a programmed identifier under an acceptance mask. The compare covers either the standard 11-bit or the extended 29-bit identifier. Frames that pass are stored whole, in one cycle.

Software programs the identifier and the mask first. It then writes a mailbox mode, and that write is what arms reception. In keep-first mode the mailbox keeps the first accepted frame until software releases it. In keep-latest mode each accepted frame replaces the previous one. A ready flag shows that a frame is waiting, and a maskable interrupt follows it. A lost flag records that a frame arrived while ready was still high. Software releases the buffer with a transfer-request strobe. Its status-read strobe clears the lost flag.

Top module: `can_rx_mailbox`

## Requirements
- R1: A frame is accepted when `((fr_id ^ cfg_id) & cfg_mask)` is zero over bits [28:0] with `cfg_ext`=1, or over bits [10:0] only with `cfg_ext`=0. In the second case bits [28:11] have no effect.
- R2: Mode codes on `cfg_mode`: 0 is off, 1 is keep-first, 2 is keep-latest, and 3 is treated as off. A `cfg_mode_wr` pulse loads the code and clears ready and lost on the next edge. A frame that arrives in the same cycle as the pulse is ignored, and so is any frame while the mode is off.
- R3: An accepted frame that finds ready low is stored (`mb_id`, `mb_data`, `mb_len`), and ready goes high on the next edge.
- R4: In keep-first mode, an accepted frame that arrives while ready is high leaves the stored frame unchanged and sets lost.
- R5: In keep-latest mode, an accepted frame that arrives while ready is high replaces the stored frame and sets lost. Ready stays high.
- R6: A `sw_xfer_req` pulse clears ready on the next edge. If an accepted frame arrives in the same cycle, that frame is stored, ready stays high and lost is not set.
- R7: A `sw_status_rd` pulse clears lost on the next edge. A lost event in the same cycle wins, and lost stays set.
- R8: `mb_irq` is high exactly while ready is high and `irq_en` is 1.
- R9: After reset the mode is off, ready and lost are 0, and the stored identifier, data and length are zero.
- R10: A frame that fails the compare changes neither the flags nor the stored frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_id | input | 29 | Programmed identifier |
| cfg_mask | input | 29 | Acceptance mask, 1 = bit compared |
| cfg_ext | input | 1 | 1 = 29-bit compare, 0 = 11-bit compare |
| cfg_mode_wr | input | 1 | Mode write strobe |
| cfg_mode | input | 2 | Mode code loaded by the strobe |
| irq_en | input | 1 | Interrupt enable for this mailbox |
| fr_valid | input | 1 | Frame valid strobe |
| fr_id | input | 29 | Frame identifier |
| fr_data | input | 64 | Frame data, byte 0 in bits [7:0] |
| fr_len | input | 4 | Frame length code |
| sw_xfer_req | input | 1 | Transfer request, releases the buffer |
| sw_status_rd | input | 1 | Status read, clears lost |
| mb_ready | output | 1 | Frame waiting |
| mb_lost | output | 1 | Frame lost |
| mb_irq | output | 1 | Mailbox interrupt |
| mb_id | output | 29 | Stored identifier |
| mb_data | output | 64 | Stored data |
| mb_len | output | 4 | Stored length |

## Verification
The assertions assume that the strobes are single-cycle pulses sampled on the rising edge. They also assume that the configuration holds steady while a frame strobe is high. They rely on internal accept, store and lost event wires, so every property is about one event and the state one edge later. The bench changes inputs only on falling edges. It redraws the identifier and mask only between frames, and it derives most frame identifiers from the programmed one so that both the accept path and the reject path are exercised.

// File: rtl/canmb_pkg.sv
package canmb_pkg;
  parameter int unsigned EXT_ID_W = 29;
  parameter int unsigned STD_ID_W = 11;

  typedef enum logic [1:0] {
    MODE_OFF        = 2'd0,
    MODE_KEEP_FIRST = 2'd1,
    MODE_KEEP_LAST  = 2'd2,
    MODE_RSVD       = 2'd3
  } mb_mode_e;

  // identifier compare under mask; ext selects the compare width
  function automatic logic id_hit(input logic [EXT_ID_W-1:0] frame_id,
                                  input logic [EXT_ID_W-1:0] prog_id,
                                  input logic [EXT_ID_W-1:0] mask,
                                  input logic                ext);
    logic [EXT_ID_W-1:0] width_sel;
    width_sel = ext ? {EXT_ID_W{1'b1}}
                    : {{(EXT_ID_W-STD_ID_W){1'b0}}, {STD_ID_W{1'b1}}};
    return ((frame_id & mask & width_sel) == (prog_id & mask & width_sel));
  endfunction

  function automatic logic mode_receives(input mb_mode_e m);
    return (m == MODE_KEEP_FIRST) || (m == MODE_KEEP_LAST);
  endfunction
endpackage

// File: rtl/canmb_filter.sv
module canmb_filter
  import canmb_pkg::*;
(
  input  logic                frame_strobe,
  input  logic [EXT_ID_W-1:0] frame_id,
  input  logic [EXT_ID_W-1:0] prog_id,
  input  logic [EXT_ID_W-1:0] prog_mask,
  input  logic                ext_sel,
  input  mb_mode_e            mode,
  input  logic                mode_write,
  output logic                accept
);
  logic hit;

  always_comb begin
    hit    = id_hit(frame_id, prog_id, prog_mask, ext_sel);
    accept = frame_strobe && hit && mode_receives(mode) && !mode_write;
  end
endmodule

// File: rtl/canmb_flags.sv
module canmb_flags
  import canmb_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  mb_mode_e mode,
  input  logic     accept,
  input  logic     release_req,
  input  logic     status_read,
  input  logic     mode_write,
  output logic     store_en,
  output logic     lost_evt,
  output logic     ready,
  output logic     lost
);
  logic buf_free;

  always_comb begin
    buf_free = !ready || release_req;
    store_en = accept && ((mode == MODE_KEEP_LAST) || buf_free);
    lost_evt = accept && !buf_free;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ready <= 1'b0;
      lost  <= 1'b0;
    end else if (mode_write) begin
      ready <= 1'b0;
      lost  <= 1'b0;
    end else begin
      if (store_en)         ready <= 1'b1;
      else if (release_req) ready <= 1'b0;
      if (lost_evt)         lost  <= 1'b1;
      else if (status_read) lost  <= 1'b0;
    end
  end
endmodule

// File: rtl/canmb_store.sv
module canmb_store #(
  parameter int unsigned ID_W    = 29,
  parameter int unsigned N_BYTES = 8,
  parameter int unsigned LEN_W   = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 store_en,
  input  logic [ID_W-1:0]      in_id,
  input  logic [N_BYTES*8-1:0] in_data,
  input  logic [LEN_W-1:0]     in_len,
  output logic [ID_W-1:0]      out_id,
  output logic [N_BYTES*8-1:0] out_data,
  output logic [LEN_W-1:0]     out_len
);
  // every lane and the header load on the same edge
  for (genvar b = 0; b < N_BYTES; b++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        out_data[b*8 +: 8] <= '0;
      else if (store_en) out_data[b*8 +: 8] <= in_data[b*8 +: 8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_id  <= '0;
      out_len <= '0;
    end else if (store_en) begin
      out_id  <= in_id;
      out_len <= in_len;
    end
  end
endmodule

// File: rtl/can_rx_mailbox.sv
module can_rx_mailbox
  import canmb_pkg::*;
#(
  parameter int unsigned N_BYTES = 8,
  parameter int unsigned LEN_W   = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [EXT_ID_W-1:0]     cfg_id,
  input  logic [EXT_ID_W-1:0]     cfg_mask,
  input  logic                    cfg_ext,
  input  logic                    cfg_mode_wr,
  input  logic [1:0]              cfg_mode,
  input  logic                    irq_en,
  input  logic                    fr_valid,
  input  logic [EXT_ID_W-1:0]     fr_id,
  input  logic [N_BYTES*8-1:0]    fr_data,
  input  logic [LEN_W-1:0]        fr_len,
  input  logic                    sw_xfer_req,
  input  logic                    sw_status_rd,
  output logic                    mb_ready,
  output logic                    mb_lost,
  output logic                    mb_irq,
  output logic [EXT_ID_W-1:0]     mb_id,
  output logic [N_BYTES*8-1:0]    mb_data,
  output logic [LEN_W-1:0]        mb_len
);
  mb_mode_e mode_q;
  logic     acc_evt;
  logic     store_evt;
  logic     lost_evt;
  logic     keep_first;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           mode_q <= MODE_OFF;
    else if (cfg_mode_wr) mode_q <= mb_mode_e'(cfg_mode);
  end

  assign keep_first = (mode_q == MODE_KEEP_FIRST);

  canmb_filter u_filter (
    .frame_strobe (fr_valid),
    .frame_id     (fr_id),
    .prog_id      (cfg_id),
    .prog_mask    (cfg_mask),
    .ext_sel      (cfg_ext),
    .mode         (mode_q),
    .mode_write   (cfg_mode_wr),
    .accept       (acc_evt)
  );

  canmb_flags u_flags (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode        (mode_q),
    .accept      (acc_evt),
    .release_req (sw_xfer_req),
    .status_read (sw_status_rd),
    .mode_write  (cfg_mode_wr),
    .store_en    (store_evt),
    .lost_evt    (lost_evt),
    .ready       (mb_ready),
    .lost        (mb_lost)
  );

  canmb_store #(
    .ID_W    (EXT_ID_W),
    .N_BYTES (N_BYTES),
    .LEN_W   (LEN_W)
  ) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .store_en (store_evt),
    .in_id    (fr_id),
    .in_data  (fr_data),
    .in_len   (fr_len),
    .out_id   (mb_id),
    .out_data (mb_data),
    .out_len  (mb_len)
  );

  assign mb_irq = mb_ready && irq_en;
endmodule

// File: rtl/canmb_checker.sv
module canmb_checker #(
  parameter int unsigned DATA_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_evt,
  input logic              store_evt,
  input logic              lost_evt,
  input logic              keep_first,
  input logic              cfg_mode_wr,
  input logic              sw_xfer_req,
  input logic              sw_status_rd,
  input logic              mb_ready,
  input logic              mb_lost,
  input logic              mb_irq,
  input logic [DATA_W-1:0] mb_data
);
  assert_store_sets_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (store_evt && !cfg_mode_wr) |=> mb_ready);

  assert_keep_first_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (keep_first && mb_ready && !sw_xfer_req && !cfg_mode_wr) |=> $stable(mb_data));

  assert_lost_event_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lost_evt |=> mb_lost);

  assert_release_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_xfer_req && !acc_evt) |=> !mb_ready);

  assert_read_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_status_rd && !lost_evt) |=> !mb_lost);

  assert_irq_needs_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mb_irq |-> mb_ready);

  assert_mode_write_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_mode_wr |=> (!mb_ready && !mb_lost));

  assert_no_accept_no_store_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_evt |-> !store_evt);
endmodule

bind can_rx_mailbox canmb_checker #(.DATA_W(N_BYTES*8)) u_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .acc_evt      (acc_evt),
  .store_evt    (store_evt),
  .lost_evt     (lost_evt),
  .keep_first   (keep_first),
  .cfg_mode_wr  (cfg_mode_wr),
  .sw_xfer_req  (sw_xfer_req),
  .sw_status_rd (sw_status_rd),
  .mb_ready     (mb_ready),
  .mb_lost      (mb_lost),
  .mb_irq       (mb_irq),
  .mb_data      (mb_data)
);

// File: tb/tb_can_rx_mailbox.sv
module tb_can_rx_mailbox;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [28:0] cfg_id = '0, cfg_mask = '0;
  logic        cfg_ext = 1'b0, cfg_mode_wr = 1'b0, irq_en = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic        fr_valid = 1'b0;
  logic [28:0] fr_id = '0;
  logic [63:0] fr_data = '0;
  logic [3:0]  fr_len = '0;
  logic        sw_xfer_req = 1'b0, sw_status_rd = 1'b0;
  logic        mb_ready, mb_lost, mb_irq;
  logic [28:0] mb_id;
  logic [63:0] mb_data;
  logic [3:0]  mb_len;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // bench reference state
  logic [1:0]  m_mode = 2'd0;
  logic        m_rdy = 1'b0, m_lost = 1'b0;
  logic [28:0] m_id = '0;
  logic [63:0] m_data = '0;
  logic [3:0]  m_len = '0;

  always #4 clk = ~clk;

  can_rx_mailbox dut (
    .clk(clk), .rst_n(rst_n), .cfg_id(cfg_id), .cfg_mask(cfg_mask), .cfg_ext(cfg_ext),
    .cfg_mode_wr(cfg_mode_wr), .cfg_mode(cfg_mode), .irq_en(irq_en),
    .fr_valid(fr_valid), .fr_id(fr_id), .fr_data(fr_data), .fr_len(fr_len),
    .sw_xfer_req(sw_xfer_req), .sw_status_rd(sw_status_rd),
    .mb_ready(mb_ready), .mb_lost(mb_lost), .mb_irq(mb_irq),
    .mb_id(mb_id), .mb_data(mb_data), .mb_len(mb_len)
  );

  function automatic bit bench_match(input logic [28:0] a, input logic [28:0] b,
                                     input logic [28:0] m, input logic ext);
    logic [28:0] diff;
    diff = (a ^ b) & m;
    if (!ext) diff[28:11] = '0;
    return diff == 29'd0;
  endfunction

  task automatic check(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    check(tag, "ready", {63'd0, mb_ready}, {63'd0, m_rdy});
    check(tag, "lost",  {63'd0, mb_lost},  {63'd0, m_lost});
    check(tag, "irq",   {63'd0, mb_irq},   {63'd0, m_rdy & irq_en});
    check(tag, "data",  mb_data, m_data);
    check(tag, "id_len", {31'd0, mb_len, mb_id}, {31'd0, m_len, m_id});
  endtask

  // called at a falling edge with inputs already driven
  task automatic step(input string tag);
    bit acc, free;
    @(posedge clk);
    acc  = fr_valid && !cfg_mode_wr && (m_mode == 2'd1 || m_mode == 2'd2)
           && bench_match(fr_id, cfg_id, cfg_mask, cfg_ext);
    free = !m_rdy || sw_xfer_req;
    if (cfg_mode_wr) begin
      m_mode = cfg_mode; m_rdy = 1'b0; m_lost = 1'b0;
    end else begin
      if (acc && (free || m_mode == 2'd2)) begin
        m_rdy = 1'b1; m_id = fr_id; m_data = fr_data; m_len = fr_len;
      end else if (sw_xfer_req) m_rdy = 1'b0;
      if (acc && !free) m_lost = 1'b1;
      else if (sw_status_rd) m_lost = 1'b0;
    end
    @(negedge clk);
    fr_valid = 1'b0; cfg_mode_wr = 1'b0; sw_xfer_req = 1'b0; sw_status_rd = 1'b0;
    compare_all(tag);
  endtask

  task automatic frame(input logic [28:0] id, input logic [63:0] d, input logic [3:0] l);
    fr_valid = 1'b1; fr_id = id; fr_data = d; fr_len = l;
  endtask

  task automatic set_mode(input logic [1:0] m);
    cfg_mode_wr = 1'b1; cfg_mode = m;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    compare_all("R9");
    rst_n = 1'b1;
    @(negedge clk);
    compare_all("R9");

    cfg_id = 29'h1555_0123; cfg_mask = '1; cfg_ext = 1'b0; irq_en = 1'b1;
    frame(29'h123, 64'h1, 4'd1); step("R2");              // mode off, ignored
    set_mode(2'd1); frame(29'h123, 64'h2, 4'd2); step("R2"); // same-cycle frame ignored
    frame(29'h0AAA_0123, 64'hDEAD_BEEF_0011_2233, 4'd8); step("R1"); // upper bits ignored
    compare_all("R3");
    frame(29'h124, 64'h99, 4'd3); step("R10");
    frame(29'h123, 64'h5555, 4'd4); step("R4");
    sw_status_rd = 1'b1; step("R7");
    irq_en = 1'b0; @(negedge clk); compare_all("R8");
    irq_en = 1'b1; @(negedge clk); compare_all("R8");
    sw_xfer_req = 1'b1; step("R6");
    frame(29'h123, 64'h7777, 4'd5); sw_xfer_req = 1'b1; step("R6");
    frame(29'h123, 64'h8888, 4'd6); sw_status_rd = 1'b1; step("R7");

    cfg_ext = 1'b1; cfg_id = 29'h1ABC_DEF0; cfg_mask = 29'h1FFF_FF00;
    set_mode(2'd2); step("R2");
    frame(29'h0ABC_DEF0, 64'h1, 4'd1); step("R1");        // bit 28 differs in ext mode
    frame(29'h1ABC_DE12, 64'hAAAA, 4'd2); step("R5");
    frame(29'h1ABC_DE34, 64'hBBBB, 4'd3); step("R5");
    set_mode(2'd3); step("R2");
    frame(29'h1ABC_DEF0, 64'hCCCC, 4'd7); step("R2");

    for (int i = 0; i < 4000; i++) begin
      if (($urandom % 50) == 0) begin
        cfg_ext = $urandom; cfg_id = $urandom; cfg_mask = $urandom | ($urandom & 29'h7FF);
        set_mode($urandom % 4);
      end else begin
        if (($urandom % 3) != 0) begin
          frame(($urandom % 4 == 0) ? 29'($urandom) : (cfg_id ^ (29'($urandom) & ~cfg_mask)),
                {$urandom, $urandom}, 4'($urandom % 9));
        end
        sw_xfer_req  = ($urandom % 4) == 0;
        sw_status_rd = ($urandom % 4) == 0;
        irq_en       = ($urandom % 8) != 0;
      end
      step("R3_R4_R5_R6_R7");
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule